// File: doc/BRIEF.md
# DRAM Bank Row-State Tracker

This block follows the row state of a single DRAM bank and tells a command scheduler, one cycle ahead, which command classes it may legally issue to that bank. The scheduler drives one-cycle strobes for activate (with a row address), read, write and precharge. The block answers with registered ready flags for activate, column access and precharge. It keeps the address of the open row and compares it with a queried row to give a hit indicator. Every timing minimum is a parameter counted in clock cycles. The minimums are activate-to-column, activate-to-precharge, precharge-to-activate, write-to-precharge (data time plus write recovery) and read-to-precharge.

The bank walks through four named states. `ST_IDLE` means precharged. In `ST_ACTIVATING` an activate has been accepted and the activate-to-column time is still running. In `ST_ACTIVE` the row is open for column commands. In `ST_PRECHARGING` a precharge has been accepted and the precharge-to-activate time is still running. The transitions are:

- IDLE→ACTIVATING on an accepted activate.
- ACTIVATING→ACTIVE when the activate-to-column time has expired.
- ACTIVE→PRECHARGING on an accepted precharge.
- PRECHARGING→IDLE when the precharge-to-activate time has expired.

If a timing parameter is 1, the intermediate state is skipped.

The block also counts column accesses to the open row. Under a two-bit page policy it raises a close request that tells the scheduler to precharge. The request stays high until a precharge or an activate is accepted. A command that arrives while its ready flag is low, or together with another strobe, is ignored and sets a sticky error flag that only reset clears.

Top module: `bank_row_tracker`

## Requirements
- R1: Reset leaves the bank idle: `act_ready_o`=1 and `col_ready_o`, `pre_ready_o`, `row_open_o`, `close_req_o` and `err_o` all 0.
- R2: After an accepted activate in cycle n, `col_ready_o` is first high in cycle n+T_RCD.
- R3: After an accepted activate in cycle n with no column command, `pre_ready_o` is first high in cycle n+T_RAS.
- R4: After an accepted precharge in cycle n, `act_ready_o` is first high in cycle n+T_RP. Two activates to the bank are therefore at least T_RAS+T_RP cycles apart.
- R5: Once T_RAS is met, a write in cycle n holds `pre_ready_o` low until cycle n+T_WDATA+T_WR, and a read in cycle n holds it low until cycle n+T_RTP.
- R6: `row_open_o` is high from the cycle after an accepted activate until the cycle after an accepted precharge. `row_hit_o` is high exactly when `row_open_o` is high and `query_row_i` equals the activated row.
- R7: `policy_i` encodings are 00 open, 01 open-adaptive, 10 close and 11 close-adaptive. On an accepted column command, the close request is set in the next cycle as follows:
  - close: always.
  - close-adaptive: when `hit_queued_i`=0.
  - open-adaptive: when `hit_queued_i`=0 and `conflict_queued_i`=1.
  - open: only at the access cap.
  
  An accepted precharge clears the close request.
- R8: After MAX_ACC accepted column commands since the last activate (default 16), `close_req_o` is 1 and `col_ready_o` is 0 under every policy.
- R9: A strobe while its ready flag is low is ignored and sets `err_o` from the next cycle; `err_o` then stays 1 until reset.
- R10: More than one strobe in a cycle is ignored and sets `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Activate strobe |
| act_row_i | input | ROW_W | Row address carried by the activate |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| pre_i | input | 1 | Precharge strobe |
| policy_i | input | 2 | Page policy: 00 open, 01 open-adaptive, 10 close, 11 close-adaptive |
| hit_queued_i | input | 1 | Another queued request targets the open row |
| conflict_queued_i | input | 1 | A queued request targets a different row of this bank |
| query_row_i | input | ROW_W | Row compared against the open row |
| act_ready_o | output | 1 | Activate may issue this cycle |
| col_ready_o | output | 1 | Read or write may issue this cycle |
| pre_ready_o | output | 1 | Precharge may issue this cycle |
| row_open_o | output | 1 | A row is open or opening |
| open_row_o | output | ROW_W | Address of the last activated row |
| row_hit_o | output | 1 | Query matches the open row |
| close_req_o | output | 1 | Page policy or access cap asks for a precharge |
| err_o | output | 1 | Sticky illegal-command flag |

## Verification
Each timing minimum is measured as the exact number of cycles from the accepted strobe to the rising ready flag. Activate-to-precharge is measured with no column traffic. Write and read are then issued after T_RAS is met, so that write recovery and read-to-precharge each show as the limiting term. The policy is exercised by a table of eight combinations of encoding, hit hint and conflict hint. The table separates the two adaptive variants from each other and from the fixed policies. Directed runs fill the open row to its access cap, issue column, precharge and simultaneous commands that should be rejected, and then confirm at the ports that the bank state did not move.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ACTIVATING  = 2'd1,
        ST_ACTIVE      = 2'd2,
        ST_PRECHARGING = 2'd3
    } bank_state_e;

    typedef enum logic [1:0] {
        PG_OPEN        = 2'b00,
        PG_OPEN_ADAPT  = 2'b01,
        PG_CLOSE       = 2'b10,
        PG_CLOSE_ADAPT = 2'b11
    } page_policy_e;

    // timer slots of the per-bank countdown array
    localparam int unsigned TM_RCD   = 0;
    localparam int unsigned TM_RAS   = 1;
    localparam int unsigned TM_RP    = 2;
    localparam int unsigned TM_WR    = 3;
    localparam int unsigned TM_RTP   = 4;
    localparam int unsigned TM_COUNT = 5;

endpackage

// File: rtl/brt_timer.sv
// Countdown for one minimum spacing. A load in cycle n makes the timer
// report expired from cycle n+LEN onward; expired_next_o is the value
// for the following cycle, so callers can register ready flags.
module brt_timer #(
    parameter int unsigned LEN = 1,
    parameter int unsigned CW  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_next_o
);
    localparam logic [CW-1:0] START = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        if (load_i) begin
            cnt_d = START;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_next_o = (cnt_d == '0);

endmodule

// File: rtl/brt_page_policy.sv
// Access counter for the open row and the close-request decision.
module brt_page_policy #(
    parameter int unsigned MAX_ACC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_ok_i,
    input  logic       col_ok_i,
    input  logic       pre_ok_i,
    input  logic [1:0] policy_i,
    input  logic       hit_queued_i,
    input  logic       conflict_queued_i,
    output logic       at_cap_next_o,
    output logic       close_req_o
);
    import brt_pkg::*;

    localparam int unsigned AW = $clog2(MAX_ACC + 1);
    localparam logic [AW-1:0] CAP      = AW'(MAX_ACC);
    localparam logic [AW-1:0] LAST_ACC = AW'(MAX_ACC - 1);

    page_policy_e  pol;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_d;
    logic          close_q;
    logic          close_d;
    logic          want_close;
    logic          cap_reached;

    assign pol = page_policy_e'(policy_i);

    always_comb begin
        unique case (pol)
            PG_OPEN:        want_close = 1'b0;
            PG_OPEN_ADAPT:  want_close = !hit_queued_i && conflict_queued_i;
            PG_CLOSE:       want_close = 1'b1;
            PG_CLOSE_ADAPT: want_close = !hit_queued_i;
            default:        want_close = 1'b0;
        endcase
    end

    assign cap_reached = col_ok_i && (acc_q == LAST_ACC);

    always_comb begin
        acc_d = acc_q;
        if (act_ok_i) begin
            acc_d = '0;
        end else if (col_ok_i && (acc_q != CAP)) begin
            acc_d = acc_q + AW'(1);
        end
    end

    always_comb begin
        close_d = close_q;
        if (act_ok_i || pre_ok_i) begin
            close_d = 1'b0;
        end else if (col_ok_i && (cap_reached || want_close)) begin
            close_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            close_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            close_q <= close_d;
        end
    end

    assign at_cap_next_o = (acc_d == CAP);
    assign close_req_o   = close_q;

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
    parameter int unsigned ROW_W   = 14,
    parameter int unsigned T_RCD   = 11,
    parameter int unsigned T_RAS   = 28,
    parameter int unsigned T_RP    = 11,
    parameter int unsigned T_WDATA = 4,
    parameter int unsigned T_WR    = 12,
    parameter int unsigned T_RTP   = 6,
    parameter int unsigned MAX_ACC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] act_row_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             pre_i,
    input  logic [1:0]       policy_i,
    input  logic             hit_queued_i,
    input  logic             conflict_queued_i,
    input  logic [ROW_W-1:0] query_row_i,
    output logic             act_ready_o,
    output logic             col_ready_o,
    output logic             pre_ready_o,
    output logic             row_open_o,
    output logic [ROW_W-1:0] open_row_o,
    output logic             row_hit_o,
    output logic             close_req_o,
    output logic             err_o
);
    import brt_pkg::*;

    localparam int unsigned T_WPRE = T_WDATA + T_WR;
    localparam int unsigned T_SUM  = T_RCD + T_RAS + T_RP + T_WPRE + T_RTP;
    localparam int unsigned CW     = $clog2(T_SUM + 1);
    localparam int unsigned TLOAD [TM_COUNT] = '{T_RCD, T_RAS, T_RP, T_WPRE, T_RTP};

    bank_state_e      state_q;
    bank_state_e      state_d;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_d;

    logic act_rdy_q, col_rdy_q, pre_rdy_q, open_q, err_q;
    logic lone, any_strobe;
    logic act_ok, rd_ok, wr_ok, pre_ok, col_ok, bad_cmd;
    logic at_cap_d;
    logic close_req;

    logic [TM_COUNT-1:0] tm_load;
    logic [TM_COUNT-1:0] tm_exp_d;

    // command acceptance
    assign any_strobe = act_i | rd_i | wr_i | pre_i;
    assign lone       = ($countones({act_i, rd_i, wr_i, pre_i}) == 1);
    assign act_ok     = act_i && lone && act_rdy_q;
    assign rd_ok      = rd_i  && lone && col_rdy_q;
    assign wr_ok      = wr_i  && lone && col_rdy_q;
    assign pre_ok     = pre_i && lone && pre_rdy_q;
    assign col_ok     = rd_ok || wr_ok;
    assign bad_cmd    = any_strobe && !(act_ok || col_ok || pre_ok);

    // per-bank timing countdowns
    always_comb begin
        tm_load         = '0;
        tm_load[TM_RCD] = act_ok;
        tm_load[TM_RAS] = act_ok;
        tm_load[TM_RP]  = pre_ok;
        tm_load[TM_WR]  = wr_ok;
        tm_load[TM_RTP] = rd_ok;
    end

    for (genvar g = 0; g < TM_COUNT; g++) begin : g_tm
        brt_timer #(
            .LEN (TLOAD[g]),
            .CW  (CW)
        ) tm_i (
            .clk            (clk),
            .rst_n          (rst_n),
            .load_i         (tm_load[g]),
            .expired_next_o (tm_exp_d[g])
        );
    end

    brt_page_policy #(
        .MAX_ACC (MAX_ACC)
    ) pol_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .act_ok_i          (act_ok),
        .col_ok_i          (col_ok),
        .pre_ok_i          (pre_ok),
        .policy_i          (policy_i),
        .hit_queued_i      (hit_queued_i),
        .conflict_queued_i (conflict_queued_i),
        .at_cap_next_o     (at_cap_d),
        .close_req_o       (close_req)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        unique case (state_q)
            ST_IDLE: begin
                if (act_ok) begin
                    row_d   = act_row_i;
                    state_d = tm_exp_d[TM_RCD] ? ST_ACTIVE : ST_ACTIVATING;
                end
            end
            ST_ACTIVATING: begin
                if (tm_exp_d[TM_RCD]) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (pre_ok) begin
                    state_d = tm_exp_d[TM_RP] ? ST_IDLE : ST_PRECHARGING;
                end
            end
            ST_PRECHARGING: begin
                if (tm_exp_d[TM_RP]) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
        end
    end

    // registered outputs, computed from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_rdy_q <= 1'b1;
            col_rdy_q <= 1'b0;
            pre_rdy_q <= 1'b0;
            open_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            act_rdy_q <= (state_d == ST_IDLE);
            col_rdy_q <= (state_d == ST_ACTIVE) && !at_cap_d;
            pre_rdy_q <= (state_d == ST_ACTIVE) && tm_exp_d[TM_RAS]
                         && tm_exp_d[TM_WR] && tm_exp_d[TM_RTP];
            open_q    <= (state_d == ST_ACTIVATING) || (state_d == ST_ACTIVE);
            err_q     <= err_q || bad_cmd;
        end
    end

    assign act_ready_o = act_rdy_q;
    assign col_ready_o = col_rdy_q;
    assign pre_ready_o = pre_rdy_q;
    assign row_open_o  = open_q;
    assign open_row_o  = row_q;
    assign row_hit_o   = open_q && (row_q == query_row_i);
    assign close_req_o = close_req;
    assign err_o       = err_q;

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
    parameter int unsigned ROW_W   = 14,
    parameter int unsigned T_RCD   = 11,
    parameter int unsigned T_RAS   = 28,
    parameter int unsigned T_RP    = 11,
    parameter int unsigned T_WDATA = 4,
    parameter int unsigned T_WR    = 12,
    parameter int unsigned T_RTP   = 6,
    parameter int unsigned MAX_ACC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act_i,
    input logic             rd_i,
    input logic             wr_i,
    input logic             pre_i,
    input logic             act_ready_o,
    input logic             col_ready_o,
    input logic             pre_ready_o,
    input logic             row_open_o,
    input logic             row_hit_o,
    input logic             err_o
);
    logic        lone;
    logic        a_ok, r_ok, w_ok, p_ok;
    logic        seen_act, seen_pre, seen_wr, seen_rd;
    logic [15:0] since_act, since_pre, since_wr, since_rd;
    logic [15:0] acc;

    assign lone = ($countones({act_i, rd_i, wr_i, pre_i}) == 1);
    assign a_ok = act_i && lone && act_ready_o;
    assign r_ok = rd_i  && lone && col_ready_o;
    assign w_ok = wr_i  && lone && col_ready_o;
    assign p_ok = pre_i && lone && pre_ready_o;

    function automatic logic [15:0] step(input logic hit, input logic [15:0] v);
        if (hit) return 16'd1;
        return (v != 16'hFFFF) ? v + 16'd1 : v;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '0; since_pre <= '0; since_wr <= '0; since_rd <= '0;
            seen_act  <= 1'b0; seen_pre <= 1'b0; seen_wr <= 1'b0; seen_rd <= 1'b0;
            acc       <= '0;
        end else begin
            since_act <= step(a_ok, since_act);
            since_pre <= step(p_ok, since_pre);
            since_wr  <= step(w_ok, since_wr);
            since_rd  <= step(r_ok, since_rd);
            seen_act  <= seen_act || a_ok;
            seen_pre  <= seen_pre || p_ok;
            seen_wr   <= seen_wr  || w_ok;
            seen_rd   <= seen_rd  || r_ok;
            if (a_ok) acc <= '0;
            else if ((r_ok || w_ok) && acc != 16'hFFFF) acc <= acc + 16'd1;
        end
    end

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_ready_o && (col_ready_o || pre_ready_o)));

    a_r2_col_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        col_ready_o |-> (seen_act && since_act >= 16'(T_RCD)));

    a_r3_pre_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ready_o |-> (seen_act && since_act >= 16'(T_RAS)));

    a_r4_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        act_ready_o |-> (!seen_pre || since_pre >= 16'(T_RP)));

    a_r5_write_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ready_o |-> (!seen_wr || since_wr >= 16'(T_WDATA + T_WR)));

    a_r5_read_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ready_o |-> (!seen_rd || since_rd >= 16'(T_RTP)));

    a_r6_hit_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        row_hit_o |-> row_open_o);

    a_r8_access_cap: assert property (@(posedge clk) disable iff (!rst_n)
        col_ready_o |-> (acc < 16'(MAX_ACC)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r9_late_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_i && !act_ready_o) || ((rd_i || wr_i) && !col_ready_o)
         || (pre_i && !pre_ready_o)) |=> err_o);

    a_r10_multi_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({act_i, rd_i, wr_i, pre_i}) > 1) |=> err_o);

endmodule

bind bank_row_tracker brt_checker #(
    .ROW_W   (ROW_W),
    .T_RCD   (T_RCD),
    .T_RAS   (T_RAS),
    .T_RP    (T_RP),
    .T_WDATA (T_WDATA),
    .T_WR    (T_WR),
    .T_RTP   (T_RTP),
    .MAX_ACC (MAX_ACC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_i       (act_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .pre_i       (pre_i),
    .act_ready_o (act_ready_o),
    .col_ready_o (col_ready_o),
    .pre_ready_o (pre_ready_o),
    .row_open_o  (row_open_o),
    .row_hit_o   (row_hit_o),
    .err_o       (err_o)
);

// File: tb/bank_row_tracker_tb_top.sv
module bank_row_tracker_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ROW_W   = 14;
    localparam int unsigned T_RCD   = 11;
    localparam int unsigned T_RAS   = 28;
    localparam int unsigned T_RP    = 11;
    localparam int unsigned T_WDATA = 4;
    localparam int unsigned T_WR    = 12;
    localparam int unsigned T_RTP   = 6;
    localparam int unsigned MAX_ACC = 16;

    // fields: [4:3] policy, [2] hit hint, [1] conflict hint, [0] expected close request
    localparam logic [4:0] POL_VEC [8] = '{
        5'b00_0_1_0, 5'b00_1_0_0, 5'b01_1_1_0, 5'b01_0_0_0,
        5'b01_0_1_1, 5'b10_1_0_1, 5'b11_1_1_0, 5'b11_0_0_1
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             act = 1'b0, rd = 1'b0, wr = 1'b0, pre = 1'b0;
    logic [ROW_W-1:0] act_row = '0;
    logic [1:0]       policy = 2'b00;
    logic             hit_q = 1'b0, conf_q = 1'b0;
    logic [ROW_W-1:0] query_row = '0;
    logic             act_ready, col_ready, pre_ready, row_open, row_hit, close_req, err;
    logic [ROW_W-1:0] open_row;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bank_row_tracker #(
        .ROW_W (ROW_W), .T_RCD (T_RCD), .T_RAS (T_RAS), .T_RP (T_RP),
        .T_WDATA (T_WDATA), .T_WR (T_WR), .T_RTP (T_RTP), .MAX_ACC (MAX_ACC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .act_i (act), .act_row_i (act_row), .rd_i (rd), .wr_i (wr), .pre_i (pre),
        .policy_i (policy), .hit_queued_i (hit_q), .conflict_queued_i (conf_q),
        .query_row_i (query_row),
        .act_ready_o (act_ready), .col_ready_o (col_ready), .pre_ready_o (pre_ready),
        .row_open_o (row_open), .open_row_o (open_row), .row_hit_o (row_hit),
        .close_req_o (close_req), .err_o (err)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic logic flag(input int sel);
        case (sel)
            0:       return act_ready;
            1:       return col_ready;
            default: return pre_ready;
        endcase
    endfunction

    // called at a negedge; counts cycles until the flag is high
    task automatic wait_flag(input int sel, output int n);
        n = 1;
        while (!flag(sel) && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // called at a negedge; strobes for one cycle, returns at the next negedge
    task automatic issue(input logic a, input logic r, input logic w, input logic p);
        act = a; rd = r; wr = w; pre = p;
        @(negedge clk);
        act = 1'b0; rd = 1'b0; wr = 1'b0; pre = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, n2;
        do_reset();
        // R1 reset state
        check("R1 act_ready", act_ready, 1);
        check("R1 col_ready", col_ready, 0);
        check("R1 pre_ready", pre_ready, 0);
        check("R1 row_open", row_open, 0);
        check("R1 close_req", close_req, 0);
        check("R1 err", err, 0);

        // R2/R3/R5/R4/R6 timing walk, open policy
        act_row = 14'h1234;
        issue(1, 0, 0, 0);
        wait_flag(1, n);
        check("R2 act to col", n, T_RCD);
        check("R6 row_open", row_open, 1);
        check("R6 open_row", open_row, 14'h1234);
        query_row = 14'h1234; #1;
        check("R6 hit", row_hit, 1);
        query_row = 14'h1235; #1;
        check("R6 miss", row_hit, 0);
        query_row = 14'h1234;
        wait_flag(2, n2);
        check("R3 act to pre", n + n2 - 1, T_RAS);
        issue(0, 0, 1, 0);
        check("R5 pre blocked after write", pre_ready, 0);
        wait_flag(2, n);
        check("R5 write to pre", n, T_WDATA + T_WR);
        issue(0, 1, 0, 0);
        wait_flag(2, n);
        check("R5 read to pre", n, T_RTP);
        issue(0, 0, 0, 1);
        check("R6 closed after pre", row_open, 0);
        check("R6 no hit after pre", row_hit, 0);
        wait_flag(0, n);
        check("R4 pre to act", n, T_RP);
        check("R9 no error so far", err, 0);

        // R4 activate to activate spacing
        issue(1, 0, 0, 0);
        wait_flag(2, n);
        issue(0, 0, 0, 1);
        wait_flag(0, n2);
        check("R4 act to act", n + n2, T_RAS + T_RP);

        // R7 policy table
        for (int i = 0; i < 8; i++) begin
            policy = POL_VEC[i][4:3];
            hit_q  = POL_VEC[i][2];
            conf_q = POL_VEC[i][1];
            issue(1, 0, 0, 0);
            wait_flag(1, n);
            issue(0, 1, 0, 0);
            check($sformatf("R7 close_req vec %0d", i), close_req, int'(POL_VEC[i][0]));
            wait_flag(2, n);
            issue(0, 0, 0, 1);
            check($sformatf("R7 cleared by pre vec %0d", i), close_req, 0);
            wait_flag(0, n);
        end

        // R8 access cap under open policy
        policy = 2'b00; hit_q = 1'b1; conf_q = 1'b0;
        issue(1, 0, 0, 0);
        wait_flag(1, n);
        for (int i = 0; i < int'(MAX_ACC); i++) begin
            issue(0, 1, 0, 0);
            check($sformatf("R8 close_req after access %0d", i + 1), close_req,
                  (i == int'(MAX_ACC) - 1) ? 1 : 0);
        end
        check("R8 col_ready at cap", col_ready, 0);
        check("R8 row still open", row_open, 1);
        check("R9 err before extra access", err, 0);
        issue(0, 1, 0, 0);
        check("R9 err after access past cap", err, 1);
        wait_flag(2, n);
        issue(0, 0, 0, 1);
        repeat (5) @(negedge clk);
        check("R9 err sticky", err, 1);

        // R9 column command while idle is ignored
        do_reset();
        check("R1 err cleared by reset", err, 0);
        issue(0, 1, 0, 0);
        check("R9 err idle read", err, 1);
        check("R9 idle read ignored row_open", row_open, 0);
        check("R9 idle read ignored act_ready", act_ready, 1);

        // R9 early precharge is ignored
        do_reset();
        act_row = 14'h0ABC;
        issue(1, 0, 0, 0);
        issue(0, 0, 0, 1);
        check("R9 err early pre", err, 1);
        wait_flag(2, n);
        check("R9 early pre ignored row_open", row_open, 1);
        check("R9 early pre ignored open_row", open_row, 14'h0ABC);

        // R10 simultaneous strobes are ignored
        do_reset();
        act_row = 14'h0055;
        issue(1, 1, 0, 0);
        check("R10 err on two strobes", err, 1);
        check("R10 act ignored row_open", row_open, 0);
        check("R10 act ignored act_ready", act_ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule